// File: doc/BRIEF.md
# Working Register File with Data-Space Mapping and Address Pointers

This block is the 8-bit working register store of a small RISC datapath. It has two combinational read ports and one clocked write port. An ALU can fetch two operands and write its result back within a single clock period. The same registers also appear at the bottom of a unified data address space. Data-memory accesses can read or write them there like ordinary locations.

The block decodes each data-space address into one of three regions: the register file, a window of peripheral control registers, or general SRAM. For the peripheral window it raises a select strobe with a window-relative offset. For SRAM it raises a separate select. Neither of those two regions touches the registers.

The top six registers pair up into three 16-bit pointers (X, Y, Z) for indirect addressing. Z is also driven out as the program-memory lookup address. A pointer can be post-incremented or pre-decremented as a single 16-bit operation. The block presents the effective address that the access should use.

Top module: `gpr_space_top`

## Requirements
- R1: The block holds 32 registers of 8 bits each. A synchronous active-low reset clears all of them to zero, and each register keeps its value until a write reaches it.
- R2: Read ports A and B are combinational. Each returns the present contents of the register its select names, and both ports may name the same register.
- R3: A register-port write (`wr_en`) commits on the rising clock edge. A read port that names the written register in the same cycle still returns the old value.
- R4: Data-space addresses 0x00 to 0x1F map to register `ds_addr[4:0]`. `ds_wr` writes that register. While `ds_rd` is high, `ds_rdata` shows its contents; otherwise `ds_rdata` is zero.
- R5: Addresses 0x20 to 0x5F, with `ds_rd` or `ds_wr` high, raise `io_sel` with `io_offset` = address − 0x20. A write there leaves every register unchanged, and `ds_rdata` stays zero.
- R6: Addresses 0x60 and above, with `ds_rd` or `ds_wr` high, raise `sram_sel` and not `io_sel`. A write there leaves every register unchanged. Neither select is raised when there is no access.
- R7: If a register-port write and a data-space write name the same register in one cycle, the register-port value is stored.
- R8: `ptr_x` = {r27,r26}, `ptr_y` = {r29,r28} and `ptr_z` = {r31,r30}, with the odd register as the high byte. `pm_addr` always equals `ptr_z`.
- R9: With `ptr_upd_en` high, `ptr_upd_sel` picks the pointer: 0 = X, 1 = Y, 2 = Z, 3 = none. `ptr_upd_dir` 0 adds one and 1 subtracts one. The whole 16-bit pair updates at the clock edge, carry or borrow crosses from the low to the high byte, and the value wraps modulo 65536. Selection 3 changes nothing.
- R10: `ptr_ea` gives the address the access uses. For post-increment it is the pointer's current value. For pre-decrement it is the current value minus one.
- R11: For each byte, priority runs from highest to lowest as register-port write, then pointer update, then data-space write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Register-port write enable |
| wr_sel | input | 5 | Register-port write index |
| wr_data | input | 8 | Register-port write data |
| ds_addr | input | 16 | Data-space address |
| ds_rd | input | 1 | Data-space read strobe |
| ds_wr | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Register data for data-space reads |
| io_sel | output | 1 | Peripheral window select |
| io_offset | output | 6 | Offset within the peripheral window |
| sram_sel | output | 1 | SRAM region select |
| ptr_upd_en | input | 1 | Pointer update enable |
| ptr_upd_sel | input | 2 | Pointer to update (0 X, 1 Y, 2 Z, 3 none) |
| ptr_upd_dir | input | 1 | 0 post-increment, 1 pre-decrement |
| ptr_ea | output | 16 | Effective address for the pointer access |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |
| pm_addr | output | 16 | Program-memory lookup address (Z) |

## Verification
The bench builds the block with its default parameters:
- 32 registers of 8 bits.
- A 16-bit data address.
- A 64-entry peripheral window based at 0x20.

These values place the pointer pairs at the top six registers. Both region edges (0x1F/0x20 and 0x5F/0x60) fall within easy reach, and so does the top of the address space at 0xFFFF. The 16-bit pointer width also makes the 0xFFFF-to-0x0000 wrap and a low-byte carry into the high byte reachable in a few cycles.

// File: rtl/gpr_pkg.sv
// Shared types for the working register file.
// Assumes: pointer selection is a 2-bit code with one "none" value.
package gpr_pkg;
    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        logic reg_hit;
        logic io_hit;
        logic sram_hit;
    } space_hit_t;
endpackage

// File: rtl/gpr_decode.sv
// Data-space region decoder: splits an address into register,
// peripheral-window and SRAM regions and forms the window offset.
// Assumes: NUM_REGS <= IO_BASE, and the SRAM region starts right after the window.
module gpr_decode
    import gpr_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NUM_REGS = 32,
    parameter int IO_BASE  = 32,
    parameter int IO_SIZE  = 64
) (
    input  logic [AW-1:0]              addr,
    output space_hit_t                 hit,
    output logic [$clog2(IO_SIZE)-1:0] io_offset
);
    localparam int IOW = $clog2(IO_SIZE);
    localparam logic [AW-1:0] REG_END = AW'(NUM_REGS);
    localparam logic [AW-1:0] IO_LO   = AW'(IO_BASE);
    localparam logic [AW-1:0] IO_HI   = AW'(IO_BASE + IO_SIZE);

    logic [AW-1:0] rel;

    // Region compare and window-relative offset.
    always_comb begin
        hit.reg_hit  = addr < REG_END;
        hit.io_hit   = (addr >= IO_LO) && (addr < IO_HI);
        hit.sram_hit = addr >= IO_HI;
        rel          = addr - IO_LO;
        io_offset    = rel[IOW-1:0];
    end
endmodule

// File: rtl/gpr_ptr_calc.sv
// Pointer arithmetic: next value and effective address for a
// post-increment or pre-decrement access.
// Assumes: the caller gates the update enable; this block is pure logic.
module gpr_ptr_calc #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] cur,
    input  logic          dec,
    output logic [PW-1:0] nxt,
    output logic [PW-1:0] ea
);
    logic [PW-1:0] minus1;

    // Full-width add or subtract so the carry crosses the byte boundary.
    always_comb begin
        minus1 = cur - PW'(1);
        nxt    = dec ? minus1 : cur + PW'(1);
        ea     = dec ? minus1 : cur;
    end
endmodule

// File: rtl/gpr_array.sv
// Register storage with two operand read ports, one data-space read
// port and per-register write arbitration.
// Priority per byte: register port, then pointer update, then data space.
// Assumes: pu_lo_idx + 1 is a valid register index whenever pu_en is high.
module gpr_array #(
    parameter int NUM_REGS = 32,
    parameter int DW       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_sel,
    output logic [DW-1:0]               rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_sel,
    output logic [DW-1:0]               rd_b_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_c_sel,
    output logic [DW-1:0]               rd_c_data,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_sel,
    input  logic [DW-1:0]               wr_data,
    input  logic                        ds_we,
    input  logic [$clog2(NUM_REGS)-1:0] ds_sel,
    input  logic [DW-1:0]               ds_wdata,
    input  logic                        pu_en,
    input  logic [$clog2(NUM_REGS)-1:0] pu_lo_idx,
    input  logic [2*DW-1:0]             pu_val,
    output logic [NUM_REGS*DW-1:0]      regs_flat
);
    localparam int SW = $clog2(NUM_REGS);

    logic [DW-1:0] mem [NUM_REGS];
    logic [SW-1:0] pu_hi_idx;

    assign pu_hi_idx = pu_lo_idx + SW'(1);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DW-1:0] q;
        logic [DW-1:0] d;

        // Write arbitration: later assignments win.
        always_comb begin
            d = q;
            if (ds_we && ds_sel == SW'(i))     d = ds_wdata;
            if (pu_en && pu_lo_idx == SW'(i))  d = pu_val[DW-1:0];
            if (pu_en && pu_hi_idx == SW'(i))  d = pu_val[2*DW-1:DW];
            if (wr_en && wr_sel == SW'(i))     d = wr_data;
        end

        // Storage element with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign mem[i] = q;
        assign regs_flat[i*DW +: DW] = q;
    end

    assign rd_a_data = mem[rd_a_sel];
    assign rd_b_data = mem[rd_b_sel];
    assign rd_c_data = mem[rd_c_sel];
endmodule

// File: rtl/gpr_space_top.sv
// Working register file mapped into the data space, with three pointers
// built from the top six registers and Z also used for program-memory lookup.
// Assumes: NUM_REGS >= 6, and pointer width is twice the register width.
module gpr_space_top
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DW       = 8,
    parameter int AW       = 16,
    parameter int IO_BASE  = 32,
    parameter int IO_SIZE  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_sel,
    output logic [DW-1:0]               rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_sel,
    output logic [DW-1:0]               rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_sel,
    input  logic [DW-1:0]               wr_data,
    input  logic [AW-1:0]               ds_addr,
    input  logic                        ds_rd,
    input  logic                        ds_wr,
    input  logic [DW-1:0]               ds_wdata,
    output logic [DW-1:0]               ds_rdata,
    output logic                        io_sel,
    output logic [$clog2(IO_SIZE)-1:0]  io_offset,
    output logic                        sram_sel,
    input  logic                        ptr_upd_en,
    input  logic [1:0]                  ptr_upd_sel,
    input  logic                        ptr_upd_dir,
    output logic [2*DW-1:0]             ptr_ea,
    output logic [2*DW-1:0]             ptr_x,
    output logic [2*DW-1:0]             ptr_y,
    output logic [2*DW-1:0]             ptr_z,
    output logic [2*DW-1:0]             pm_addr
);
    localparam int SW       = $clog2(NUM_REGS);
    localparam int PW       = 2 * DW;
    localparam int PTR_BASE = NUM_REGS - 6;
    localparam int NUM_PTR  = 3;

    space_hit_t            hit;
    ptr_sel_e              psel;
    logic                  access;
    logic                  ds_we;
    logic                  pu_en;
    logic [SW-1:0]         pu_lo_idx;
    logic [PW-1:0]         pu_cur;
    logic [PW-1:0]         pu_nxt;
    logic [DW-1:0]         rd_c_data;
    logic [NUM_REGS*DW-1:0] regs_flat;
    logic [PW-1:0]         ptr_val [NUM_PTR];

    gpr_decode #(
        .AW(AW), .NUM_REGS(NUM_REGS), .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE)
    ) u_dec (
        .addr(ds_addr), .hit(hit), .io_offset(io_offset)
    );

    // Region strobes and data-space write qualification.
    always_comb begin
        access   = ds_rd | ds_wr;
        io_sel   = access & hit.io_hit;
        sram_sel = access & hit.sram_hit;
        ds_we    = ds_wr & hit.reg_hit;
        ds_rdata = (ds_rd && hit.reg_hit) ? rd_c_data : '0;
    end

    // Assemble each pointer from its low/high register pair.
    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        assign ptr_val[p] = {regs_flat[(PTR_BASE+2*p+1)*DW +: DW],
                             regs_flat[(PTR_BASE+2*p)*DW +: DW]};
    end

    assign ptr_x   = ptr_val[0];
    assign ptr_y   = ptr_val[1];
    assign ptr_z   = ptr_val[2];
    assign pm_addr = ptr_val[2];

    // Select the pointer to update and locate its low-byte register.
    always_comb begin
        psel      = ptr_sel_e'(ptr_upd_sel);
        pu_en     = ptr_upd_en && (psel != PTR_NONE);
        pu_lo_idx = SW'(PTR_BASE) + SW'({ptr_upd_sel, 1'b0});
        pu_cur    = (psel == PTR_NONE) ? '0 : ptr_val[ptr_upd_sel];
    end

    gpr_ptr_calc #(.PW(PW)) u_pcalc (
        .cur(pu_cur), .dec(ptr_upd_dir), .nxt(pu_nxt), .ea(ptr_ea)
    );

    gpr_array #(.NUM_REGS(NUM_REGS), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .rd_c_sel(ds_addr[SW-1:0]), .rd_c_data(rd_c_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ds_we(ds_we), .ds_sel(ds_addr[SW-1:0]), .ds_wdata(ds_wdata),
        .pu_en(pu_en), .pu_lo_idx(pu_lo_idx), .pu_val(pu_nxt),
        .regs_flat(regs_flat)
    );
endmodule

// File: rtl/gpr_space_chk.sv
// Assertion checker for gpr_space_top, attached by bind below.
// Assumes: it sees only the top-level ports.
module gpr_space_chk #(
    parameter int NUM_REGS = 32,
    parameter int DW       = 8,
    parameter int AW       = 16,
    parameter int IO_BASE  = 32,
    parameter int IO_SIZE  = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(NUM_REGS)-1:0] rd_a_sel,
    input logic [DW-1:0]               rd_a_data,
    input logic [$clog2(NUM_REGS)-1:0] rd_b_sel,
    input logic [DW-1:0]               rd_b_data,
    input logic                        wr_en,
    input logic [$clog2(NUM_REGS)-1:0] wr_sel,
    input logic [DW-1:0]               wr_data,
    input logic [AW-1:0]               ds_addr,
    input logic                        ds_wr,
    input logic                        ptr_upd_en,
    input logic [1:0]                  ptr_upd_sel,
    input logic                        ptr_upd_dir,
    input logic [2*DW-1:0]             ptr_x,
    input logic [2*DW-1:0]             ptr_y,
    input logic [2*DW-1:0]             ptr_z
);
    localparam int SW = $clog2(NUM_REGS);
    localparam int PW = 2 * DW;

    // R3
    port_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd_a_sel == $past(wr_sel))
        |-> rd_a_data == $past(wr_data));

    // R7
    port_over_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && wr_en && ds_wr && ds_addr < AW'(NUM_REGS)
               && ds_addr[SW-1:0] == wr_sel) && rd_b_sel == $past(wr_sel))
        |-> rd_b_data == $past(wr_data));

    // R9
    z_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ptr_upd_en && ptr_upd_sel == 2'd2 && !ptr_upd_dir
              && !wr_en && !ds_wr)
        |-> ptr_z == $past(ptr_z) + PW'(1));

    // R5, R6
    window_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ds_wr && ds_addr >= AW'(NUM_REGS) && !wr_en && !ptr_upd_en)
        |-> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !wr_en && !ds_wr && !ptr_upd_en)
         && rd_a_sel == $past(rd_a_sel))
        |-> $stable(rd_a_data));
endmodule

bind gpr_space_top gpr_space_chk #(
    .NUM_REGS(NUM_REGS), .DW(DW), .AW(AW), .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE)
) u_chk (.*);

// File: tb/tb_gpr_space_top.sv
// Directed bench for gpr_space_top: one task per scenario.
module tb_gpr_space_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
    logic        wr_en, ds_rd, ds_wr;
    logic [15:0] ds_addr;
    logic        io_sel, sram_sel;
    logic [5:0]  io_offset;
    logic        ptr_upd_en, ptr_upd_dir;
    logic [1:0]  ptr_upd_sel;
    logic [15:0] ptr_ea, ptr_x, ptr_y, ptr_z, pm_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] mdl [32];

    always #2 clk = ~clk;

    gpr_space_top dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; ds_rd = 0; ds_wr = 0; ptr_upd_en = 0;
        ptr_upd_sel = 2'd3; ptr_upd_dir = 0;
    endtask

    task automatic port_wr(input logic [4:0] s, input logic [7:0] v);
        @(negedge clk); idle(); wr_en = 1; wr_sel = s; wr_data = v;
        @(negedge clk); idle(); mdl[s] = v;
    endtask

    task automatic chk_reg(input string req, input logic [4:0] s);
        rd_a_sel = s; rd_b_sel = s; #1;
        check(req, {24'd0, rd_a_data}, {24'd0, mdl[s]});
        check(req, {24'd0, rd_b_data}, {24'd0, mdl[s]});
    endtask

    task automatic t_reset();
        check("R1 reset r0", {24'd0, rd_a_data}, 0);
        rd_a_sel = 5'd31; rd_b_sel = 5'd17; #1;
        check("R1 reset r31", {24'd0, rd_a_data}, 0);
        check("R1 reset r17", {24'd0, rd_b_data}, 0);
        check("R8 reset ptrs", {ptr_x, ptr_y}, 0);
        check("R8 reset z", {16'd0, ptr_z}, 0);
    endtask

    task automatic t_port();
        // R3: same-cycle read returns the old value
        @(negedge clk); idle(); wr_en = 1; wr_sel = 5; wr_data = 8'hA5;
        rd_a_sel = 5; #1;
        check("R3 old value", {24'd0, rd_a_data}, 0);
        @(negedge clk); idle(); mdl[5] = 8'hA5;
        chk_reg("R3 committed", 5);
        for (int i = 0; i < 32; i++) port_wr(5'(i), 8'(i * 7 + 3));
        for (int i = 0; i < 32; i++) chk_reg("R2 read ports", 5'(i));
        rd_a_sel = 3; rd_b_sel = 9; #1;
        check("R2 distinct ports", {16'd0, rd_a_data, rd_b_data}, {16'd0, mdl[3], mdl[9]});
    endtask

    task automatic t_ds();
        @(negedge clk); idle(); ds_wr = 1; ds_addr = 16'h0003; ds_wdata = 8'h3C; #1;
        check("R4 no select", {30'd0, io_sel, sram_sel}, 0);
        @(negedge clk); idle(); mdl[3] = 8'h3C;
        chk_reg("R4 ds write", 3);
        ds_rd = 1; ds_addr = 16'h001F; #1;
        check("R4 ds read", {24'd0, ds_rdata}, {24'd0, mdl[31]});
        ds_rd = 0; #1;
        check("R4 no read", {24'd0, ds_rdata}, 0);
    endtask

    task automatic t_io();
        @(negedge clk); idle(); ds_rd = 1; ds_addr = 16'h0020; #1;
        check("R5 low edge", {24'd0, io_sel, sram_sel, io_offset}, {24'd0, 2'b10, 6'd0});
        ds_addr = 16'h005F; #1;
        check("R5 high edge", {24'd0, io_sel, sram_sel, io_offset}, {24'd0, 2'b10, 6'd63});
        ds_addr = 16'h001F; #1;
        check("R5 below", {31'd0, io_sel}, 0);
        ds_addr = 16'h0025; #1;
        check("R5 rdata zero", {24'd0, ds_rdata}, 0);
        @(negedge clk); idle(); ds_wr = 1; ds_addr = 16'h0025; ds_wdata = 8'hFF;
        @(negedge clk); idle();
        chk_reg("R5 regs untouched", 5);
    endtask

    task automatic t_sram();
        @(negedge clk); idle(); ds_wr = 1; ds_addr = 16'h0060; #1;
        check("R6 low edge", {30'd0, io_sel, sram_sel}, 1);
        ds_addr = 16'hFFFF; #1;
        check("R6 top", {30'd0, io_sel, sram_sel}, 1);
        ds_addr = 16'h0065; ds_wdata = 8'hEE;
        @(negedge clk); idle(); #1;
        check("R6 no access", {30'd0, io_sel, sram_sel}, 0);
        chk_reg("R6 regs untouched", 5);
    endtask

    task automatic t_prio();
        @(negedge clk); idle(); wr_en = 1; wr_sel = 7; wr_data = 8'h11;
        ds_wr = 1; ds_addr = 16'h0007; ds_wdata = 8'h22;
        @(negedge clk); idle(); mdl[7] = 8'h11;
        chk_reg("R7 port wins", 7);
    endtask

    task automatic t_ptr();
        port_wr(26, 8'hFF); port_wr(27, 8'h12);
        #1 check("R8 X pair", {16'd0, ptr_x}, 32'h12FF);
        @(negedge clk); idle(); ptr_upd_en = 1; ptr_upd_sel = 0; ptr_upd_dir = 0; #1;
        check("R10 post-inc ea", {16'd0, ptr_ea}, 32'h12FF);
        @(negedge clk); idle(); #1;
        check("R9 X carry", {16'd0, ptr_x}, 32'h1300);
        port_wr(30, 8'h00); port_wr(31, 8'h40);
        @(negedge clk); idle(); ptr_upd_en = 1; ptr_upd_sel = 2; ptr_upd_dir = 1; #1;
        check("R10 pre-dec ea", {16'd0, ptr_ea}, 32'h3FFF);
        @(negedge clk); idle(); #1;
        check("R9 Z borrow", {16'd0, ptr_z}, 32'h3FFF);
        check("R8 pm_addr", {16'd0, pm_addr}, 32'h3FFF);
        port_wr(28, 8'hFF); port_wr(29, 8'hFF);
        #1 check("R8 Y pair", {16'd0, ptr_y}, 32'hFFFF);
        @(negedge clk); idle(); ptr_upd_en = 1; ptr_upd_sel = 1; ptr_upd_dir = 0;
        @(negedge clk); idle(); #1;
        check("R9 Y wrap", {16'd0, ptr_y}, 0);
        @(negedge clk); idle(); ptr_upd_en = 1; ptr_upd_sel = 3; ptr_upd_dir = 0;
        @(negedge clk); idle(); #1;
        check("R9 none sel", {ptr_x, ptr_z}, {16'h1300, 16'h3FFF});
        check("R9 none sel Y", {16'd0, ptr_y}, 0);
    endtask

    task automatic t_ptr_prio();
        port_wr(26, 8'hFF); port_wr(27, 8'h00);
        @(negedge clk); idle(); ptr_upd_en = 1; ptr_upd_sel = 0; ptr_upd_dir = 0;
        wr_en = 1; wr_sel = 27; wr_data = 8'h55;
        ds_wr = 1; ds_addr = 16'h001A; ds_wdata = 8'h77;
        @(negedge clk); idle(); #1;
        check("R11 byte priority", {16'd0, ptr_x}, 32'h5500);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        rst_n = 0; idle(); rd_a_sel = 0; rd_b_sel = 0; wr_sel = 0; wr_data = 0;
        ds_addr = 0; ds_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        t_reset();
        t_port();
        t_ds();
        t_io();
        t_sram();
        t_prio();
        t_ptr();
        t_ptr_prio();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule